// File: doc/BRIEF.md
# Fetch Address Generator with Instruction Queue

This block sits at the front of an instruction fetch stage. It holds the 32-bit address of the next instruction to fetch, and it keeps fetched instruction words in a short first-in first-out queue that feeds the decode stage. Refill words arrive on one of two return ports, a cache read port or a prefetch buffer port. Each accepted word is tagged with the address it was fetched from, and the address then moves on by one instruction.

When the queue holds no complete instruction, the block asks for more by raising a fill request. A redirect from the write-back stage loads a new target into the address register. The same redirect flushes every queued word and drops any return data that arrives in that cycle, so decode never sees an instruction from the abandoned path. Decode drains the queue through a valid/ready pair.

Top module: `fetch_addr_queue`

## Requirements
- R1: During and after a synchronous active-high reset, `fetch_addr` equals `RESET_ADDR` (default 0), `dec_valid` is 0 and `fill_req` is 1.
- R2: Each word accepted into the queue moves `fetch_addr` up by 4 at the next clock edge. When no word is accepted and no redirect occurs, `fetch_addr` holds its value.
- R3: When `redir_valid` is high, `fetch_addr` takes `redir_addr` at the next edge. This overrides any step in the same cycle.
- R4: Words leave in the order they were accepted. Each output word comes with `dec_addr`, the value `fetch_addr` had when that word was accepted.
- R5: A redirect empties the queue and discards return data presented in the same cycle. `dec_valid` is 0 in the cycle after the redirect.
- R6: The queue holds `DEPTH` (default 4) entries. A word offered while the queue is full, even in a cycle where an entry is popped, is ignored: the address does not step and the word never reaches the output.
- R7: `fill_req` is high exactly when occupancy is below `FILL_MARK` (default 1, meaning the queue is empty). It is low whenever the queue is full.
- R8: At most one word is accepted per cycle. When both `cache_valid` and `pbuf_valid` are high, the cache word is taken and the prefetch word is dropped.
- R9: An entry pops when `dec_valid` and `dec_ready` are both high. While `dec_ready` is low and no redirect occurs, `dec_valid`, `dec_word` and `dec_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| redir_valid | input | 1 | Redirect strobe from write-back |
| redir_addr | input | 32 | Redirect target address |
| cache_valid | input | 1 | Cache return word valid |
| cache_word | input | 32 | Cache return instruction |
| pbuf_valid | input | 1 | Prefetch buffer return word valid |
| pbuf_word | input | 32 | Prefetch buffer return instruction |
| fill_req | output | 1 | Request for more instructions |
| fetch_addr | output | 32 | Address of the next instruction to fetch |
| dec_valid | output | 1 | Queue head is valid |
| dec_ready | input | 1 | Decode accepts the head word |
| dec_word | output | 32 | Head instruction word |
| dec_addr | output | 32 | Fetch address of the head word |

## Verification
The assertions assume that `rst` is held for at least one edge before traffic starts. They also assume the return ports may assert valid in any cycle, whether or not a fill was requested, so a full queue has to be safe against unsolicited words. The stimulus respects the reset rule and deliberately offers words while the queue is full, presents both sources in the same cycle, and issues redirects both while words are arriving and while decode pops an entry. Decode readiness follows a fixed irregular pattern, so the hold-while-stalled property is exercised with data present.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int INSTR_W = 32;
  localparam int ADDR_W  = 32;

  typedef struct packed {
    logic [ADDR_W-1:0]  pc;
    logic [INSTR_W-1:0] word;
  } fq_entry_t;

  localparam int ENTRY_W = $bits(fq_entry_t);
endpackage

// File: rtl/fq_src_sel.sv
// Picks one return word per cycle; the cache port wins a tie.
module fq_src_sel
  import fq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cache_valid,
  input  logic [INSTR_W-1:0] cache_word,
  input  logic               pbuf_valid,
  input  logic [INSTR_W-1:0] pbuf_word,
  output logic               in_valid,
  output logic [INSTR_W-1:0] in_word
);
  always_comb begin
    in_valid = cache_valid | pbuf_valid;
    in_word  = cache_valid ? cache_word : pbuf_word;
  end

  // R8: a tie must yield the cache word
  p_cache_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (cache_valid && pbuf_valid) |-> (in_valid && in_word == cache_word));
endmodule

// File: rtl/fq_addr_gen.sv
// Fetch address register: redirect load or sequential step.
module fq_addr_gen
  import fq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter int                STEP       = INSTR_W / 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              redir,
  input  logic [ADDR_W-1:0] redir_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)        addr <= RESET_ADDR;
    else if (redir) addr <= redir_addr;
    else if (step)  addr <= addr + STEP_V;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!redir && step) |=> (addr == $past(addr) + STEP_V));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!redir && !step) |=> $stable(addr));
  p_redir_load_r3: assert property (@(posedge clk) disable iff (rst)
    redir |=> (addr == $past(redir_addr)));
endmodule

// File: rtl/fq_ring.sv
// Circular buffer; storage has no reset so it maps to distributed/block RAM.
module fq_ring #(
  parameter int DEPTH = 4,
  parameter int W     = 64
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int  CNT_W = $clog2(DEPTH + 1);
  localparam bit  POW2  = ((DEPTH & (DEPTH - 1)) == 0);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C);
  p_push_free_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_pop_present_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  p_flush_empties_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/fetch_addr_queue.sv
module fetch_addr_queue
  import fq_pkg::*;
#(
  parameter int                DEPTH      = 4,
  parameter int                FILL_MARK  = 1,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               redir_valid,
  input  logic [ADDR_W-1:0]  redir_addr,
  input  logic               cache_valid,
  input  logic [INSTR_W-1:0] cache_word,
  input  logic               pbuf_valid,
  input  logic [INSTR_W-1:0] pbuf_word,
  output logic               fill_req,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic [INSTR_W-1:0] dec_word,
  output logic [ADDR_W-1:0]  dec_addr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] MARK_C = CNT_W'(FILL_MARK);

  logic               in_valid;
  logic [INSTR_W-1:0] in_word;
  logic               take, pop, full, empty;
  logic [CNT_W-1:0]   count;
  fq_entry_t          wr_ent, rd_ent;

  fq_src_sel u_sel (
    .clk         (clk),
    .rst         (rst),
    .cache_valid (cache_valid),
    .cache_word  (cache_word),
    .pbuf_valid  (pbuf_valid),
    .pbuf_word   (pbuf_word),
    .in_valid    (in_valid),
    .in_word     (in_word)
  );

  // A word is taken only into a free slot and never in a redirect cycle.
  assign take = in_valid && !full && !redir_valid;
  assign pop  = dec_valid && dec_ready;

  fq_addr_gen #(.RESET_ADDR(RESET_ADDR)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .redir      (redir_valid),
    .redir_addr (redir_addr),
    .step       (take),
    .addr       (fetch_addr)
  );

  assign wr_ent.pc   = fetch_addr;
  assign wr_ent.word = in_word;

  fq_ring #(.DEPTH(DEPTH), .W(ENTRY_W)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .flush (redir_valid),
    .push  (take),
    .pop   (pop),
    .wdata (wr_ent),
    .rdata (rd_ent),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  // All outputs below depend only on registered queue state.
  assign dec_valid = !empty;
  assign dec_word  = rd_ent.word;
  assign dec_addr  = rd_ent.pc;
  assign fill_req  = (count < MARK_C) && !full;

  p_flush_r5: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !dec_valid);
  p_fill_empty_r7: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> fill_req);
  p_full_nofill_r7: assert property (@(posedge clk) disable iff (rst)
    full |-> !fill_req);
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready && !redir_valid) |=>
      (dec_valid && $stable(dec_word) && $stable(dec_addr)));
  p_full_noaddr_r6: assert property (@(posedge clk) disable iff (rst)
    (full && !redir_valid) |=> $stable(fetch_addr));
endmodule

// File: tb/tb_fetch_addr_queue.sv
module tb_fetch_addr_queue;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_addr  = '0;
  logic        cache_valid = 1'b0;
  logic [31:0] cache_word  = '0;
  logic        pbuf_valid  = 1'b0;
  logic [31:0] pbuf_word   = '0;
  logic        dec_ready   = 1'b0;
  logic        fill_req, dec_valid;
  logic [31:0] fetch_addr, dec_word, dec_addr;

  fetch_addr_queue dut (
    .clk(clk), .rst(rst), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .cache_valid(cache_valid), .cache_word(cache_word),
    .pbuf_valid(pbuf_valid), .pbuf_word(pbuf_word),
    .fill_req(fill_req), .fetch_addr(fetch_addr), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_word(dec_word), .dec_addr(dec_addr)
  );

  always #4 clk = ~clk;

  typedef struct { logic [31:0] a; logic [31:0] w; } item_t;
  item_t       sb[$];
  logic [31:0] m_addr = '0;
  int          total = 0, bad = 0;
  bit          mon_on = 0;
  logic [31:0] held;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected item.
  task automatic drive(input bit cv, input logic [31:0] ci, input bit pv,
                       input logic [31:0] pi, input bit rdy, input bit rv,
                       input logic [31:0] ra);
    bit    acc;
    item_t it;
    @(negedge clk);
    cache_valid = cv; cache_word = ci;
    pbuf_valid  = pv; pbuf_word  = pi;
    dec_ready   = rdy;
    redir_valid = rv; redir_addr = ra;
    #1;
    acc  = !rv && (cv || pv) && (sb.size() < DEPTH);   // R6 R8
    it.a = m_addr;
    it.w = cv ? ci : pi;
    @(posedge clk); #1;
    if (rv) begin
      sb.delete();
      m_addr = ra;
    end else if (acc) begin
      sb.push_back(it);
      m_addr += 32'd4;
    end
  endtask

  task automatic idle(input bit rdy);
    drive(1'b0, '0, 1'b0, '0, rdy, 1'b0, '0);
  endtask

  // Monitor: compares every cycle against the scoreboard.
  initial forever begin
    @(negedge clk); #2;
    if (mon_on) begin
      chk(fetch_addr === m_addr, "R2 R3 fetch address", fetch_addr, m_addr);
      chk(dec_valid === (sb.size() != 0), "R9 output valid", {31'd0, dec_valid},
          {31'd0, sb.size() != 0});
      chk(fill_req === (sb.size() < 1), "R7 fill request", {31'd0, fill_req},
          {31'd0, sb.size() < 1});
      if (dec_valid === 1'b1 && sb.size() != 0) begin
        chk(dec_word === sb[0].w, "R4 head word", dec_word, sb[0].w);
        chk(dec_addr === sb[0].a, "R4 head address", dec_addr, sb[0].a);
        if (dec_ready) void'(sb.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(fetch_addr === 32'd0, "R1 reset address", fetch_addr, 32'd0);
    chk(dec_valid === 1'b0, "R1 reset valid", {31'd0, dec_valid}, 32'd0);
    chk(fill_req === 1'b1, "R1 reset fill request", {31'd0, fill_req}, 32'd1);
    @(negedge clk);
    rst = 1'b0;
    mon_on = 1;

    // Fill from both sources while decode stalls.
    drive(1'b1, 32'hC000_0001, 1'b0, '0, 1'b0, 1'b0, '0);
    drive(1'b1, 32'hC000_0002, 1'b0, '0, 1'b0, 1'b0, '0);
    held = dec_word;
    drive(1'b0, '0, 1'b1, 32'hB000_0003, 1'b0, 1'b0, '0);
    chk(dec_word === held, "R9 stalled head holds", dec_word, held);
    drive(1'b0, '0, 1'b1, 32'hB000_0004, 1'b0, 1'b0, '0);
    #1;
    chk(fill_req === 1'b0, "R7 full suppresses fill", {31'd0, fill_req}, 32'd0);
    // Offer while full: ignored.
    drive(1'b1, 32'hDEAD_0005, 1'b0, '0, 1'b0, 1'b0, '0);
    #1;
    chk(fetch_addr === 32'd16, "R6 full ignores word", fetch_addr, 32'd16);
    // Offer while full and popping: still ignored.
    drive(1'b1, 32'hDEAD_0006, 1'b1, 32'hDEAD_0007, 1'b1, 1'b0, '0);
    #1;
    chk(fetch_addr === 32'd16, "R6 full with pop ignores word", fetch_addr, 32'd16);
    repeat (4) idle(1'b1);

    // Tie between sources.
    drive(1'b1, 32'hC000_0010, 1'b1, 32'hB000_0010, 1'b0, 1'b0, '0);
    #1;
    chk(dec_word === 32'hC000_0010, "R8 cache wins tie", dec_word, 32'hC000_0010);
    chk(fetch_addr === 32'd20, "R8 one word per cycle", fetch_addr, 32'd20);
    drive(1'b0, '0, 1'b1, 32'hB000_0011, 1'b0, 1'b0, '0);

    // Redirect with a word arriving and a pop in the same cycle.
    drive(1'b1, 32'hDEAD_0012, 1'b0, '0, 1'b1, 1'b1, 32'h0000_1000);
    #1;
    chk(dec_valid === 1'b0, "R5 flush clears queue", {31'd0, dec_valid}, 32'd0);
    chk(fetch_addr === 32'h0000_1000, "R3 redirect target", fetch_addr, 32'h0000_1000);

    // Streaming with mixed sources, stalls and a mid-stream redirect.
    for (int i = 0; i < 60; i++) begin
      drive((i % 3) != 2, 32'hC100_0000 + i, (i % 2) == 0, 32'hB100_0000 + i,
            (i % 4) != 1, i == 30, 32'h0000_2000);
    end
    repeat (6) idle(1'b1);
    #1;
    chk(dec_valid === 1'b0, "R9 drained", {31'd0, dec_valid}, 32'd0);

    mon_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule